// File: doc/BRIEF.md
# Line-Doubling Scan Converter

This block re-times a console picture onto a progressive monitor raster. Decoded 9-bit palette indices arrive one per source pixel, framed by a line-start pulse and a frame-start pulse. Three of the nine bits select colour emphasis. Each source line is written into one of two alternating line stores. The other store, which holds the line finished just before, is read out twice at the output pixel rate, one output pixel per clock. So every source line fills two consecutive output lines.

The output raster runs from a free-running pixel counter, so the horizontal period never depends on the source. Only the line counter is pulled back into step at each source frame start. A source frame that is a dot short therefore ends up as a slightly shorter output frame, and horizontal sync does not jitter. Each index read back passes through a 512-entry RGB table to produce 24-bit colour. Sync and blank outputs are delayed so that they line up with the colour.

Top module: `scan_doubler`

## Requirements
- R1: Two line stores alternate. The write store changes only on a clock where `src_line` is high. Output lines read the store that is not being written, so a source line written during one source line period is shown during the next.
- R2: Output row 2r and row 2r+1 both show source line r of the current frame, pixel for pixel. Rows count from 0 at the first active output line after frame alignment.
- R3: Colour is `rgb = {idx[8:1], ~idx[7:0], idx[2:0], idx[8:4]}`, with red in bits 23:16, green in 15:8 and blue in 7:0. The table covers all 512 indices, including those with emphasis bits 8:6 set.
- R4: The horizontal counter `h` is 0 during reset and advances by one every clock, wrapping at `H_TOTAL`. `vid_hsync` is high for `h` in [`HS_START`, `HS_START+HS_LEN`). Every port output shows the state of counter position (h, v) two clocks after the counter held it.
- R5: The line counter `v` advances when `h` wraps and wraps at `V_TOTAL`. A `src_frame` pulse seen anywhere in a line makes the next line take `v = V_TOTAL-2`. The first active row therefore starts two output lines after the line holding the pulse, and a frame one dot short leaves the horizontal period unchanged.
- R6: `vid_vsync` is high for `v` in [`VS_START`, `VS_START+VS_LEN`), which lies wholly in the blanked lines.
- R7: Active means `h < H_ACT` and `v < 2*IN_LINES`. Outside that region `vid_blank` is 1 and `vid_rgb` is 0.
- R8: After a `src_line` pulse, only the first `H_ACT` pixels with `src_valid` high are stored. Any further pixels on that line do not disturb the stored ones.
- R9: While `rst_n` is low, `vid_blank` is 1 and `vid_rgb`, `vid_hsync` and `vid_vsync` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock; source pixels come as enables on it |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | 1 | A source pixel is present this clock |
| src_index | input | 9 | Palette index with emphasis bits 8:6 |
| src_line | input | 1 | One-clock source line-start pulse |
| src_frame | input | 1 | One-clock source frame-start pulse |
| vid_rgb | output | 24 | Output colour, red in the top byte |
| vid_hsync | output | 1 | Output horizontal sync, active high |
| vid_vsync | output | 1 | Output vertical sync, active high |
| vid_blank | output | 1 | High outside the active picture |

## Verification
On every active clock, one store is written with the incoming source line while the other is read for the second copy of the previous line. The swap on `src_line` also falls within a few pixels of the output line wrap. The bench drives source lines whose pixels land during reads of the opposite store, and puts extra pixels past the end of a line. It shortens the pre-render line by one source dot, which moves both the swap and the frame re-alignment two clocks earlier. Every output clock is compared against a raster model built from the requirements, with expected colours taken from the pixels that were driven.

// File: rtl/scan_pkg.sv
package scan_pkg;
   localparam int IDX_W     = 9;
   localparam int RGB_W     = 24;
   localparam int PAL_DEPTH = 1 << IDX_W;

   typedef logic [IDX_W-1:0] pal_idx_t;
   typedef logic [RGB_W-1:0] rgb_t;

   // initial colour image: red from upper index bits, green inverted low byte,
   // blue a rotation so emphasis bits reach every channel
   function automatic rgb_t pal_seed(input pal_idx_t i);
      return {i[8:1], ~i[7:0], i[2:0], i[8:4]};
   endfunction
endpackage

// File: rtl/scan_raster.sv
module scan_raster #(
   parameter int H_TOTAL  = 341,
   parameter int H_ACT    = 256,
   parameter int HS_START = 280,
   parameter int HS_LEN   = 32,
   parameter int V_TOTAL  = 525,
   parameter int V_ACT    = 480,
   parameter int VS_START = 490,
   parameter int VS_LEN   = 2,
   localparam int HW = $clog2(H_TOTAL),
   localparam int VW = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          realign,
   output logic [HW-1:0] h,
   output logic [VW-1:0] v,
   output logic          act,
   output logic          hs,
   output logic          vs
);
   localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
   localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
   localparam logic [VW-1:0] V_LOAD = VW'(V_TOTAL - 2);

   initial begin
      assert (H_TOTAL > H_ACT);
      assert (HS_START >= H_ACT && HS_START + HS_LEN <= H_TOTAL);
      assert (V_TOTAL >= V_ACT + 2);
      assert (VS_START >= V_ACT && VS_START + VS_LEN <= V_TOTAL);
   end

   logic pend;
   logic wrap;
   assign wrap = (h == H_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h    <= '0;
         v    <= '0;
         pend <= 1'b0;
      end else begin
         if (wrap) begin
            h <= '0;
            if (pend)            v <= V_LOAD;
            else if (v == V_LAST) v <= '0;
            else                 v <= v + 1'b1;
         end else begin
            h <= h + 1'b1;
         end
         if (realign)   pend <= 1'b1;
         else if (wrap) pend <= 1'b0;
      end
   end

   always_comb begin
      act = (int'(h) < H_ACT) && (int'(v) < V_ACT);
      hs  = (int'(h) >= HS_START) && (int'(h) < HS_START + HS_LEN);
      vs  = (int'(v) >= VS_START) && (int'(v) < VS_START + VS_LEN);
   end
endmodule

// File: rtl/scan_linebuf.sv
module scan_linebuf #(
   parameter int DEPTH = 256,
   parameter int DW    = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic          wr_bank,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_bank,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);
   initial assert (DEPTH >= 2 && (1 << AW) == DEPTH);

   logic rd_bank_q;

   for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en && wr_bank == 1'(b)) mem[wr_addr] <= wr_data;
         q <= mem[rd_addr];
      end
   end

   always_ff @(posedge clk) rd_bank_q <= rd_bank;

   assign rd_data = rd_bank_q ? g_bank[1].q : g_bank[0].q;
endmodule

// File: rtl/scan_palette.sv
module scan_palette
   import scan_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  pal_idx_t idx,
   input  logic     act,
   output rgb_t     rgb
);
   rgb_t rom [PAL_DEPTH];

   initial begin
      for (int i = 0; i < PAL_DEPTH; i++) rom[i] = pal_seed(pal_idx_t'(i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   rgb <= '0;
      else if (act) rgb <= rom[idx];
      else          rgb <= '0;
   end
endmodule

// File: rtl/scan_doubler.sv
module scan_doubler
   import scan_pkg::*;
#(
   parameter int H_ACT    = 256,
   parameter int IN_LINES = 240,
   parameter int H_TOTAL  = 341,
   parameter int HS_START = 280,
   parameter int HS_LEN   = 32,
   parameter int V_TOTAL  = 525,
   parameter int VS_START = 490,
   parameter int VS_LEN   = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        src_valid,
   input  logic [8:0]  src_index,
   input  logic        src_line,
   input  logic        src_frame,
   output logic [23:0] vid_rgb,
   output logic        vid_hsync,
   output logic        vid_vsync,
   output logic        vid_blank
);
   localparam int V_ACT = 2 * IN_LINES;
   localparam int AW    = $clog2(H_ACT);
   localparam int CW    = $clog2(H_ACT + 1);
   localparam int HW    = $clog2(H_TOTAL);
   localparam int VW    = $clog2(V_TOTAL);

   initial assert (IDX_W == 9 && RGB_W == 24);

   // write side: store select flips per source line, column saturates
   logic          wr_sel;
   logic [CW-1:0] wr_col;
   logic          wr_en;

   assign wr_en = src_valid && !src_line && (int'(wr_col) < H_ACT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_sel <= 1'b0;
         wr_col <= CW'(H_ACT);
      end else if (src_line) begin
         wr_sel <= ~wr_sel;
         wr_col <= '0;
      end else if (wr_en) begin
         wr_col <= wr_col + 1'b1;
      end
   end

   // output raster
   logic [HW-1:0] h;
   logic [VW-1:0] v;
   logic          act0, hs0, vs0;

   scan_raster #(
      .H_TOTAL(H_TOTAL), .H_ACT(H_ACT), .HS_START(HS_START), .HS_LEN(HS_LEN),
      .V_TOTAL(V_TOTAL), .V_ACT(V_ACT), .VS_START(VS_START), .VS_LEN(VS_LEN)
   ) u_raster (
      .clk(clk), .rst_n(rst_n), .realign(src_frame),
      .h(h), .v(v), .act(act0), .hs(hs0), .vs(vs0)
   );

   // line stores
   pal_idx_t rd_idx;

   scan_linebuf #(.DEPTH(H_ACT), .DW(IDX_W)) u_lines (
      .clk(clk),
      .wr_en(wr_en), .wr_bank(wr_sel), .wr_addr(wr_col[AW-1:0]), .wr_data(src_index),
      .rd_bank(~wr_sel), .rd_addr(h[AW-1:0]), .rd_data(rd_idx)
   );

   // stage 1 carries raster flags beside the store read
   logic act1, hs1, vs1;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act1 <= 1'b0;
         hs1  <= 1'b0;
         vs1  <= 1'b0;
      end else begin
         act1 <= act0;
         hs1  <= hs0;
         vs1  <= vs0;
      end
   end

   // stage 2: colour lookup and aligned sync
   scan_palette u_pal (
      .clk(clk), .rst_n(rst_n), .idx(rd_idx), .act(act1), .rgb(vid_rgb)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vid_hsync <= 1'b0;
         vid_vsync <= 1'b0;
         vid_blank <= 1'b1;
      end else begin
         vid_hsync <= hs1;
         vid_vsync <= vs1;
         vid_blank <= ~act1;
      end
   end
endmodule

// File: rtl/scan_doubler_chk.sv
module scan_doubler_chk #(
   parameter int H_ACT   = 256,
   parameter int H_TOTAL = 341,
   localparam int CW     = $clog2(H_ACT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          src_line,
   input logic          wr_sel,
   input logic [CW-1:0] wr_col,
   input logic [23:0]   vid_rgb,
   input logic          vid_hsync,
   input logic          vid_vsync,
   input logic          vid_blank
);
   logic        hs_q;
   logic        seen;
   logic [31:0] gap;
   logic        hs_rise;

   assign hs_rise = vid_hsync && !hs_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         seen <= 1'b0;
         gap  <= '0;
      end else begin
         hs_q <= vid_hsync;
         if (hs_rise) begin
            seen <= 1'b1;
            gap  <= '0;
         end else begin
            gap  <= gap + 1'b1;
         end
      end
   end

   // R1
   swap_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel != $past(wr_sel)) |-> $past(src_line));

   // R4
   hs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_rise && seen) |-> (gap == 32'(H_TOTAL - 1)));

   // R7
   blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_blank |-> (vid_rgb == 24'h0));

   // R6
   vs_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vid_vsync |-> vid_blank);

   // R8
   col_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(wr_col) <= H_ACT);
endmodule

bind scan_doubler scan_doubler_chk #(.H_ACT(H_ACT), .H_TOTAL(H_TOTAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_line(src_line), .wr_sel(wr_sel), .wr_col(wr_col),
   .vid_rgb(vid_rgb), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_blank(vid_blank)
);

// File: tb/scan_doubler_bench.sv
module scan_doubler_bench;
   localparam int CLK_PERIOD = 10;
   localparam int B_HACT = 16, B_LINES = 4, B_HTOT = 24, B_HS = 18, B_HSL = 3;
   localparam int B_VTOT = 13, B_VS = 9, B_VSL = 1;
   localparam int SRC_LINE_CLK = 2 * B_HTOT;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        src_valid = 1'b0, src_line = 1'b0, src_frame = 1'b0;
   logic [8:0]  src_index = '0;
   logic [23:0] vid_rgb;
   logic        vid_hsync, vid_vsync, vid_blank;

   always #(CLK_PERIOD/2) clk = ~clk;

   scan_doubler #(
      .H_ACT(B_HACT), .IN_LINES(B_LINES), .H_TOTAL(B_HTOT), .HS_START(B_HS), .HS_LEN(B_HSL),
      .V_TOTAL(B_VTOT), .VS_START(B_VS), .VS_LEN(B_VSL)
   ) u_scan_doubler (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_index(src_index),
      .src_line(src_line), .src_frame(src_frame),
      .vid_rgb(vid_rgb), .vid_hsync(vid_hsync), .vid_vsync(vid_vsync), .vid_blank(vid_blank)
   );

   int errors = 0;
   int checks = 0;
   bit mon_en = 1'b0;

   task automatic check(input bit ok, input string req, input logic [31:0] actv, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, actv, expv, $time);
      end
   endtask

   function automatic logic [23:0] pal_ref(input logic [8:0] i);
      return {i[8:1], ~i[7:0], i[2:0], i[8:4]};
   endfunction

   typedef struct packed { logic [8:0] idx; logic [23:0] rgb; } vec_t;
   localparam vec_t VEC [8] = '{
      '{9'h000, 24'h00FF00}, '{9'h1FF, 24'hFF00FF}, '{9'h100, 24'h80FF10}, '{9'h001, 24'h00FE20},
      '{9'h0A5, 24'h525AAA}, '{9'h15A, 24'hADA555}, '{9'h03C, 24'h1EC383}, '{9'h1C3, 24'hE13C7C}
   };

   logic [8:0]  pixmem [4][4][16];
   logic [23:0] cap_tab [2][8];
   logic [23:0] cap_r8 [3];

   // raster model from R4/R5, two-clock output delay
   int mh, mv, mfr, vscnt;
   bit pend, mval;
   int e1h, e1v, e1f, e2h, e2v, e2f;
   bit e1val, e2val, e1live, e2live;

   always @(posedge clk) begin
      if (!rst_n) begin
         mh <= 0; mv <= 0; mfr <= 0; vscnt <= 0; pend <= 0; mval <= 0;
         e1live <= 0; e2live <= 0;
      end else begin
         if (mh == B_HTOT - 1) begin
            mh <= 0;
            if (pend) begin mv <= B_VTOT - 2; mfr <= vscnt - 1; mval <= 1; end
            else mv <= (mv == B_VTOT - 1) ? 0 : mv + 1;
            pend <= 0;
         end else mh <= mh + 1;
         if (src_frame) begin pend <= 1; vscnt <= vscnt + 1; end
         e1h <= mh; e1v <= mv; e1f <= mfr; e1val <= mval; e1live <= 1;
         e2h <= e1h; e2v <= e1v; e2f <= e1f; e2val <= e1val; e2live <= e1live;
      end
   end

   always @(negedge clk) begin
      if (rst_n && mon_en && e2live) begin
         automatic bit act = (e2h < B_HACT) && (e2v < 2 * B_LINES);
         automatic bit hexp = (e2h >= B_HS) && (e2h < B_HS + B_HSL);
         automatic bit vexp = (e2v >= B_VS) && (e2v < B_VS + B_VSL);
         check(vid_blank == !act, "R7 blank", 32'(vid_blank), 32'(!act));
         check(vid_hsync == hexp, "R4 hsync", 32'(vid_hsync), 32'(hexp));
         check(vid_vsync == vexp, "R5 R6 vsync", 32'(vid_vsync), 32'(vexp));
         if (!act) check(vid_rgb == 24'h0, "R7 rgb zero", 32'(vid_rgb), 32'h0);
         else if (e2val) begin
            automatic logic [23:0] ex = pal_ref(pixmem[e2f][e2v/2][e2h]);
            check(vid_rgb == ex, "R1 R2 R3 rgb", 32'(vid_rgb), 32'(ex));
            if (e2f == 0 && e2v < 2 && e2h < 8) cap_tab[e2v][e2h] = vid_rgb;
            if (e2f == 0 && e2v == 4 && e2h < 3) cap_r8[e2h] = vid_rgb;
         end
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic send_line(input int fr, input int ln, input int len);
      int used;
      src_line = 1'b1; src_frame = (ln == 0); src_valid = 1'b0;
      tick();
      src_line = 1'b0; src_frame = 1'b0;
      used = 1;
      if (ln < B_LINES) begin
         for (int x = 0; x < B_HACT; x++) begin
            src_valid = 1'b1; src_index = pixmem[fr][ln][x]; tick();
            src_valid = 1'b0; tick();
            used += 2;
         end
         if (fr == 0 && ln == 2) begin
            // R8: surplus pixels beyond the line width
            for (int e = 0; e < 3; e++) begin
               src_valid = 1'b1; src_index = 9'h1FF; tick();
               src_valid = 1'b0; tick();
               used += 2;
            end
         end
      end
      while (used < len) begin tick(); used++; end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int f = 0; f < 4; f++)
         for (int l = 0; l < 4; l++)
            for (int x = 0; x < 16; x++)
               pixmem[f][l][x] = 9'((f * 97 + l * 37 + x * 11 + 5) % 512);
      for (int k = 0; k < 8; k++) pixmem[0][0][k] = VEC[k].idx;

      // R9 reset state
      repeat (4) tick();
      check(vid_blank == 1'b1, "R9 blank in reset", 32'(vid_blank), 32'h1);
      check(vid_rgb == 24'h0, "R9 rgb in reset", 32'(vid_rgb), 32'h0);
      check(vid_hsync == 1'b0 && vid_vsync == 1'b0, "R9 syncs in reset",
            32'({vid_hsync, vid_vsync}), 32'h0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      repeat (B_HTOT - 4) tick();

      // frame 1 has its pre-render line one source dot short (R5)
      for (int fr = 0; fr < 4; fr++)
         for (int ln = 0; ln < 6; ln++)
            send_line(fr, ln, (fr == 1 && ln == 5) ? SRC_LINE_CLK - 2 : SRC_LINE_CLK);
      mon_en = 1'b0;

      // R3 and R2: table vectors walked on both copies of the first source line
      for (int k = 0; k < 8; k++) begin
         check(cap_tab[0][k] == VEC[k].rgb, "R3 palette row0", 32'(cap_tab[0][k]), 32'(VEC[k].rgb));
         check(cap_tab[1][k] == VEC[k].rgb, "R2 palette row1", 32'(cap_tab[1][k]), 32'(VEC[k].rgb));
      end
      // R8: surplus pixels left the start of the line intact
      for (int x = 0; x < 3; x++)
         check(cap_r8[x] == pal_ref(pixmem[0][2][x]), "R8 surplus ignored",
               32'(cap_r8[x]), 32'(pal_ref(pixmem[0][2][x])));

      // R9 reset reapplied mid-raster
      rst_n = 1'b0;
      tick();
      check(vid_blank == 1'b1 && vid_rgb == 24'h0 && !vid_hsync && !vid_vsync,
            "R9 re-reset", 32'({vid_blank, vid_hsync, vid_vsync}), 32'h4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule